// File: doc/BRIEF.md
# Limit counter-timer with reached flag

This block is a periodic counter-timer. An input strobe marks each count period (nominally 500 ns). On every strobe the counter steps up by one unit. The unit sits at bit 9 of a 32-bit word, so the low nine bits always read as zero. When the count meets the programmed limit, three things happen on the same strobe. The counter restarts from zero, a sticky reached flag is set and a level interrupt is raised. A program can therefore use the block as a periodic tick source. A limit of zero turns the block into a free-running counter that flags each time it rolls over its full range.

Software reaches the block through a simple single-cycle port with four word addresses. Read data is combinational, and any side effect of an access takes effect at the clock edge that ends the access. Word 0 holds the limit. Writing it restarts the count, and reading it acknowledges the interrupt. Word 1 returns the count with the reached flag in bit 31. Word 2 accepts a new limit but leaves the running count alone. Word 3 is unused.

Top module: `limit_timer`

## Requirements
- R1: Each cycle with `tick` high and no bus write raises the count by one unit of 0x200. Bits 8..0 of every read are zero.
- R2: A read of word 1 returns the count in bits 30..9 and the reached flag in bit 31.
- R3: On the tick where count+1 equals a non-zero limit, the count becomes zero, the reached flag is set and `irq` goes high. Counting then repeats with the same period.
- R4: With a limit of zero, the counter runs to the largest count field value (all ones). On that tick it returns to zero and sets the reached flag and `irq`.
- R5: A write to word 0 stores `wdata & 0x7FFFFE00` as the limit, clears the count to zero and lowers `irq`. The reached flag keeps its value.
- R6: A write to word 2 stores the limit with the same masking and leaves the count unchanged.
- R7: A read of word 0 returns the limit in bits 30..9 with bit 31 zero. It also lowers `irq` and clears the reached flag. If a limit match happens in the same cycle, the match wins and the flag and `irq` are set.
- R8: After reset the limit is zero, the count is zero, the reached flag is clear and `irq` is low.
- R9: A bus write cycle suppresses that cycle's tick. Writes to words 1 and 3 change nothing. A read of word 2 or word 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-period strobe, one cycle wide |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the boundary where count+1 meets the limit. A compare that is off by one would flag a tick early or late, or would let the count show the limit value. It checks that a limit read in the same cycle as a match leaves the flag set; a design with the wrong priority would lose that interrupt. It checks that a restart write lowers `irq` but keeps the flag, and that a word 2 write keeps the count. A design that confused the two writes would zero the count or drop the flag. Free-run rollover is checked on a narrow count field, and an over-wide mask would show up as stray low bits or a set bit 31 in the limit read.

// File: rtl/limit_timer_pkg.sv
package limit_timer_pkg;
    typedef enum logic [1:0] {
        WA_LIMIT      = 2'd0,
        WA_COUNT      = 2'd1,
        WA_LIMIT_KEEP = 2'd2,
        WA_SPARE      = 2'd3
    } word_addr_e;
endpackage

// File: rtl/lt_step.sv
module lt_step #(
    parameter int CW = 22
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count_next,
    output logic          hit
);
    logic [CW-1:0] lim_eff;
    logic [CW-1:0] inc;

    always_comb begin
        lim_eff    = (limit == '0) ? '1 : limit;
        inc        = count + 1'b1;
        hit        = (inc == lim_eff);
        count_next = hit ? '0 : inc;
    end
endmodule

// File: rtl/lt_rdmux.sv
module lt_rdmux
    import limit_timer_pkg::*;
#(
    parameter int LSB = 9,
    parameter int MSB = 30,
    localparam int CW = MSB - LSB + 1
) (
    input  logic [1:0]    addr,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] limit,
    input  logic          reached,
    output logic [31:0]   rdata
);
    always_comb begin
        rdata = '0;
        case (word_addr_e'(addr))
            WA_LIMIT: rdata[MSB:LSB] = limit;
            WA_COUNT: begin
                rdata[MSB:LSB] = count;
                rdata[31]      = reached;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/limit_timer.sv
module limit_timer
    import limit_timer_pkg::*;
#(
    parameter int LSB = 9,
    parameter int MSB = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int CW = MSB - LSB + 1;

    typedef struct packed {
        logic [CW-1:0] limit;
        logic [CW-1:0] count;
        logic          reached;
        logic          irq;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] step_count;
    logic          step_hit;
    logic          wr, rd;

    lt_step #(.CW(CW)) i_step (
        .count      (st_q.count),
        .limit      (st_q.limit),
        .count_next (step_count),
        .hit        (step_hit)
    );

    lt_rdmux #(.LSB(LSB), .MSB(MSB)) i_rdmux (
        .addr    (bus_addr),
        .count   (st_q.count),
        .limit   (st_q.limit),
        .reached (st_q.reached),
        .rdata   (bus_rdata)
    );

    always_comb begin
        wr   = bus_sel && bus_we;
        rd   = bus_sel && !bus_we;
        st_d = st_q;
        if (rd && word_addr_e'(bus_addr) == WA_LIMIT) begin
            st_d.irq     = 1'b0;
            st_d.reached = 1'b0;
        end
        if (wr) begin
            case (word_addr_e'(bus_addr))
                WA_LIMIT: begin
                    st_d.limit = bus_wdata[MSB:LSB];
                    st_d.count = '0;
                    st_d.irq   = 1'b0;
                end
                WA_LIMIT_KEEP: st_d.limit = bus_wdata[MSB:LSB];
                default: ;
            endcase
        end else if (tick) begin
            st_d.count = step_count;
            if (step_hit) begin
                st_d.reached = 1'b1;
                st_d.irq     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/limit_timer_chk.sv
module limit_timer_chk #(
    parameter int LSB = 9,
    parameter int CW  = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [1:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          irq,
    input logic [CW-1:0] count_q,
    input logic          reached_q
);
    p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we |-> bus_rdata[LSB-1:0] == '0);

    p_hit_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reached_q) |-> irq && count_q == '0);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reached_q);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == 2'd0 |=> count_q == '0 && !irq);

    p_keep_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_we && bus_addr == 2'd2 |=> $stable(count_q));

    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_we && bus_addr == 2'd0 && !tick |=> !irq && !reached_q);

    p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !(bus_sel && bus_we && bus_addr == 2'd0) |=> $stable(count_q));
endmodule

bind limit_timer limit_timer_chk #(.LSB(LSB), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count_q   (st_q.count),
    .reached_q (st_q.reached)
);

// File: tb/test_limit_timer.sv
module test_limit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, sel = 1'b0, we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0, rdata;
    logic        irq;
    logic        f_tick = 1'b0, f_sel = 1'b0;
    logic [31:0] f_rdata;
    logic        f_irq;
    int          checks = 0, errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    limit_timer i_limit_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

    limit_timer #(.LSB(9), .MSB(12)) i_limit_timer_free (
        .clk(clk), .rst_n(rst_n), .tick(f_tick), .bus_sel(f_sel), .bus_we(1'b0),
        .bus_addr(2'd1), .bus_wdata(32'd0), .bus_rdata(f_rdata), .irq(f_irq));

    typedef struct packed {
        logic [7:0]  ticks;
        logic        we;
        logic [1:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'd0, 1'b1, 2'd0, 32'h0000_0A00},
        '{8'd4, 1'b0, 2'd1, 32'h0000_0800},
        '{8'd1, 1'b0, 2'd1, 32'h8000_0000},
        '{8'd0, 1'b0, 2'd0, 32'h0000_0A00},
        '{8'd0, 1'b0, 2'd1, 32'h0000_0000},
        '{8'd3, 1'b0, 2'd1, 32'h0000_0600},
        '{8'd0, 1'b1, 2'd2, 32'h0000_1000},
        '{8'd0, 1'b0, 2'd1, 32'h0000_0600},
        '{8'd4, 1'b0, 2'd1, 32'h0000_0E00},
        '{8'd1, 1'b0, 2'd1, 32'h8000_0000},
        '{8'd0, 1'b1, 2'd0, 32'hFFFF_FFFF},
        '{8'd0, 1'b0, 2'd0, 32'h7FFF_FE00},
        '{8'd2, 1'b0, 2'd1, 32'h0000_0400},
        '{8'd0, 1'b0, 2'd3, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            @(negedge clk) tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic bus(input logic w, input logic [1:0] a, input logic [31:0] d,
                       input logic t, output logic [31:0] r);
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; wdata = d; tick = t;
        #1 r = rdata;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; tick = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        bus(1'b0, 2'd0, 0, 1'b0, rv); chk("R8 limit", rv, 32'h0);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R8 count", rv, 32'h0);
        chk("R8 irq", {31'd0, irq}, 32'h0);

        // R1 R2 R3 R5 R6 R7 R9 table walk
        for (int i = 0; i < NV; i++) begin
            do_ticks(int'(VEC[i].ticks));
            bus(VEC[i].we, VEC[i].addr, VEC[i].data, 1'b0, rv);
            if (!VEC[i].we) chk($sformatf("R1/R2/R3/R5/R6/R7/R9 vec %0d", i), rv, VEC[i].data);
        end

        // R3 irq raised on match and held through count reads, periodic
        bus(1'b1, 2'd0, 32'h0000_0600, 1'b0, rv);
        do_ticks(3);
        #1 chk("R3 irq at match", {31'd0, irq}, 32'h1);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R3 count zero flag", rv, 32'h8000_0000);
        chk("R3 irq held", {31'd0, irq}, 32'h1);
        // R5 restart write lowers irq, keeps flag
        bus(1'b1, 2'd0, 32'h0000_0600, 1'b0, rv);
        #1 chk("R5 irq low", {31'd0, irq}, 32'h0);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R5 flag kept", rv, 32'h8000_0000);
        // R7 ack clears flag
        bus(1'b0, 2'd0, 0, 1'b0, rv); chk("R7 limit read", rv, 32'h0000_0600);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R7 flag cleared", rv, 32'h0);
        // R3 second period
        do_ticks(2);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R3 period count", rv, 32'h0000_0400);
        do_ticks(1);
        #1 chk("R3 second irq", {31'd0, irq}, 32'h1);
        bus(1'b0, 2'd0, 0, 1'b0, rv);
        #1 chk("R7 irq lowered", {31'd0, irq}, 32'h0);

        // R7 match in same cycle as ack: match wins
        do_ticks(2);
        bus(1'b0, 2'd0, 0, 1'b1, rv);
        #1 chk("R7 match wins irq", {31'd0, irq}, 32'h1);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R7 match wins flag", rv, 32'h8000_0000);
        bus(1'b0, 2'd0, 0, 1'b0, rv);

        // R9 write suppresses tick; writes to words 1 and 3 ignored; word 2 reads zero
        do_ticks(1);
        bus(1'b1, 2'd2, 32'h0000_0600, 1'b1, rv);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R9 tick suppressed", rv, 32'h0000_0200);
        bus(1'b1, 2'd1, 32'h7FFF_FFFF, 1'b0, rv);
        bus(1'b1, 2'd3, 32'h7FFF_FFFF, 1'b0, rv);
        bus(1'b0, 2'd1, 0, 1'b0, rv); chk("R9 count ignored writes", rv, 32'h0000_0200);
        bus(1'b0, 2'd0, 0, 1'b0, rv); chk("R9 limit ignored writes", rv, 32'h0000_0600);
        bus(1'b0, 2'd2, 0, 1'b0, rv); chk("R9 word2 reads zero", rv, 32'h0);

        // R4 free-run rollover on a 4-bit count field
        @(negedge clk) f_tick = 1'b1;
        repeat (14) @(negedge clk);
        f_tick = 1'b0; f_sel = 1'b1;
        #1 chk("R4 count at top-1", f_rdata, 32'h0000_1C00);
        chk("R4 no irq yet", {31'd0, f_irq}, 32'h0);
        f_tick = 1'b1; f_sel = 1'b0;
        @(negedge clk) f_tick = 1'b0; f_sel = 1'b1;
        #1 chk("R4 rollover flag", f_rdata, 32'h8000_0000);
        chk("R4 rollover irq", {31'd0, f_irq}, 32'h1);
        f_sel = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule